// File: doc/BRIEF.md
# Row/Column Co-Gated SRAM Array

This block is a synthesizable model of an embedded SRAM array with fine-grained power gating. Each physical wordline is cut into equal slices as wide as the data port. Every slice carries its own gate enable. A slice's local wordline and its gate enable are both the AND of the global row line from the row decoder and the slice's column select. As a result, an access wakes exactly one slice of the array, however long the wordline is. The model shows which row/slice pair it powers and keeps a validity bit for every stored word, so contents lost to a supply cut are reported instead of being returned silently.

A requester presents a row address, a slice select, a read/write flag and write data. Reads return one cycle later. Two array-wide controls request low-power states. The hold control keeps the contents. The shutdown control discards them. A small power-mode state machine has four states: ACTIVE, RETAIN, CUTOFF and WAKE. Any asserted shutdown moves it to CUTOFF, and shutdown wins over hold. Otherwise an asserted hold moves it to RETAIN. When both controls drop while in RETAIN or CUTOFF, it goes to WAKE. WAKE is a single settling cycle that limits ground bounce, and it moves to ACTIVE if both controls stay low. When both controls are low in ACTIVE, the machine stays in ACTIVE. The array serves accesses only in ACTIVE, and only while both controls are low.

Top module: `cogated_sram`

## Requirements
- R1: The number of slices per row is WL_BITS/IO_BITS. In the cycle after an accepted access, `block_power` has only bit row*(WL_BITS/IO_BITS)+slice set. In every other cycle it is all zeros.
- R2: A read accepted at a clock edge raises `rvalid` for exactly the following cycle. In that cycle `rdata` shows the addressed word. A write never raises `rvalid`.
- R3: A write changes only the addressed slice of the addressed row. Every other slice of that row, and every other row, keeps its value.
- R4: After reset, every word is invalid. A read of an invalid word returns `rdata` = 0 with `rd_invalid` high. The word stays invalid until it is written.
- R5: `shutdown` high at any clock edge makes every stored word invalid.
- R6: Words stored before a period of `hold` read back unchanged once the array is ACTIVE again.
- R7: An access is rejected when it is presented while `hold` or `shutdown` is high, or while the machine is not in ACTIVE. A rejected access writes nothing, powers no slice and raises no `rvalid`. `pwr_err` is high in the following cycle, and only then.
- R8: When both controls drop while in RETAIN or CUTOFF, the machine passes through exactly one WAKE cycle. Accesses in the cycle the controls drop and in the WAKE cycle are rejected. The next access is accepted.
- R9: When `hold` and `shutdown` are both high, shutdown wins: the contents are invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Row address |
| req_blk | input | $clog2(WL_BITS/IO_BITS) | Slice (column) select |
| wdata | input | IO_BITS | Write data |
| hold | input | 1 | Retention request; contents kept |
| shutdown | input | 1 | Cut-off request; contents lost |
| rdata | output | IO_BITS | Read data, valid with rvalid |
| rvalid | output | 1 | Read result present |
| rd_invalid | output | 1 | Read hit a word with no valid content |
| pwr_err | output | 1 | Previous-cycle access was rejected by power state |
| block_power | output | ROWS*WL_BITS/IO_BITS | One-hot powered row/slice pair |

## Verification
The bench writes neighbouring slices of one row with distinct values. A decoder that ANDed the wrong column, or wrote a whole row, would corrupt the neighbours and fail the readback. It asserts hold and shutdown together. A design that let hold take priority would then return stale data instead of flagging it invalid. It drops the controls while accesses are pending. A missing WAKE cycle would accept an access one cycle too early. A wrongly sampled control would let an access through while hold was high. Random traffic compares every cycle's block_power, read data and flags with a bench model.

// File: rtl/cg_sram_pkg.sv
package cg_sram_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_RETAIN = 2'd1,
        PM_CUTOFF = 2'd2,
        PM_WAKE   = 2'd3
    } pm_state_e;

endpackage

// File: rtl/cg_power_fsm.sv
module cg_power_fsm
    import cg_sram_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  logic      shutdown,
    output pm_state_e state_o,
    output logic      ready_o,
    output logic      wipe_o
);

    pm_state_e state_q;
    pm_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_ACTIVE: begin
                if (shutdown)  state_d = PM_CUTOFF;
                else if (hold) state_d = PM_RETAIN;
            end
            PM_RETAIN: begin
                if (shutdown)   state_d = PM_CUTOFF;
                else if (!hold) state_d = PM_WAKE;
            end
            PM_CUTOFF: begin
                if (shutdown)  state_d = PM_CUTOFF;
                else if (hold) state_d = PM_RETAIN;
                else           state_d = PM_WAKE;
            end
            PM_WAKE: begin
                if (shutdown)  state_d = PM_CUTOFF;
                else if (hold) state_d = PM_RETAIN;
                else           state_d = PM_ACTIVE;
            end
            default: state_d = PM_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        state_o = state_q;
        ready_o = (state_q == PM_ACTIVE) && !hold && !shutdown;
        wipe_o  = shutdown;
    end

endmodule

// File: rtl/cg_decoder.sv
module cg_decoder #(
    parameter int ROWS = 16,
    parameter int NBLK = 4,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic               en,
    input  logic [RW-1:0]      row,
    input  logic [BW-1:0]      blk,
    output logic [ROWS*NBLK-1:0] lwl
);

    logic [ROWS-1:0] row_hot;
    logic [NBLK-1:0] col_hot;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_hot[r] = en && (row == RW'(r));
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_col
        assign col_hot[b] = (blk == BW'(b));
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_and_r
        for (genvar b = 0; b < NBLK; b++) begin : g_and_b
            assign lwl[r*NBLK+b] = row_hot[r] & col_hot[b];
        end
    end

endmodule

// File: rtl/cg_block.sv
module cg_block #(
    parameter int ROWS    = 16,
    parameter int IO_BITS = 16,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROWS-1:0]    lwl,
    input  logic               wr,
    input  logic [RW-1:0]      row,
    input  logic [IO_BITS-1:0] wdata,
    input  logic               wipe,
    output logic [IO_BITS-1:0] rq,
    output logic               rv
);

    logic [IO_BITS-1:0] mem [ROWS];
    logic [ROWS-1:0]    vld;
    logic               hit;

    assign hit = |lwl;

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr && lwl[r]) mem[r] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wipe) begin
            vld <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (wr && lwl[r]) vld[r] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq <= '0;
            rv <= 1'b0;
        end else if (hit && !wr) begin
            rq <= mem[row];
            rv <= vld[row];
        end
    end

endmodule

// File: rtl/cogated_sram.sv
module cogated_sram
    import cg_sram_pkg::*;
#(
    parameter int ROWS    = 16,
    parameter int WL_BITS = 64,
    parameter int IO_BITS = 16,
    localparam int NBLK = WL_BITS / IO_BITS,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int PW   = ROWS * NBLK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [RW-1:0]      req_row,
    input  logic [BW-1:0]      req_blk,
    input  logic [IO_BITS-1:0] wdata,
    input  logic               hold,
    input  logic               shutdown,
    output logic [IO_BITS-1:0] rdata,
    output logic               rvalid,
    output logic               rd_invalid,
    output logic               pwr_err,
    output logic [PW-1:0]      block_power
);

    pm_state_e          pm_state;
    logic               ready;
    logic               wipe;
    logic               accept;
    logic [PW-1:0]      lwl;
    logic [ROWS-1:0]    col_lwl [NBLK];
    logic [IO_BITS-1:0] blk_rq  [NBLK];
    logic               blk_rv  [NBLK];
    logic               rd_q;
    logic [BW-1:0]      blk_q;
    logic               sel_v;

    cg_power_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .shutdown (shutdown),
        .state_o  (pm_state),
        .ready_o  (ready),
        .wipe_o   (wipe)
    );

    assign accept = req_valid && ready;

    cg_decoder #(.ROWS(ROWS), .NBLK(NBLK)) u_dec (
        .en  (accept),
        .row (req_row),
        .blk (req_blk),
        .lwl (lwl)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        for (genvar r = 0; r < ROWS; r++) begin : g_tap
            assign col_lwl[b][r] = lwl[r*NBLK+b];
        end
        cg_block #(.ROWS(ROWS), .IO_BITS(IO_BITS)) u_blk (
            .clk   (clk),
            .rst_n (rst_n),
            .lwl   (col_lwl[b]),
            .wr    (req_write),
            .row   (req_row),
            .wdata (wdata),
            .wipe  (wipe),
            .rq    (blk_rq[b]),
            .rv    (blk_rv[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q        <= 1'b0;
            blk_q       <= '0;
            block_power <= '0;
            pwr_err     <= 1'b0;
        end else begin
            rd_q        <= accept && !req_write;
            blk_q       <= req_blk;
            block_power <= lwl;
            pwr_err     <= req_valid && !ready;
        end
    end

    always_comb begin
        sel_v      = blk_rv[blk_q];
        rvalid     = rd_q;
        rd_invalid = rd_q && !sel_v;
        rdata      = (rd_q && sel_v) ? blk_rq[blk_q] : '0;
    end

endmodule

// File: rtl/cg_sram_chk.sv
module cg_sram_chk #(
    parameter int PW = 64,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          hold,
    input logic          shutdown,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input logic          rd_invalid,
    input logic          pwr_err,
    input logic [PW-1:0] block_power
);

    // R1
    pwr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(block_power));

    // R2
    read_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $countones(block_power) == 1);

    // R4
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid |-> (rvalid && rdata == '0));

    // R7
    gated_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (hold || shutdown)) |=> (pwr_err && block_power == '0));

    // R7
    err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_err |-> !rvalid);

endmodule

bind cogated_sram cg_sram_chk #(.PW(ROWS*(WL_BITS/IO_BITS)), .DW(IO_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .hold        (hold),
    .shutdown    (shutdown),
    .rdata       (rdata),
    .rvalid      (rvalid),
    .rd_invalid  (rd_invalid),
    .pwr_err     (pwr_err),
    .block_power (block_power)
);

// File: tb/test_cogated_sram.sv
`timescale 1ns/1ps
module test_cogated_sram;

    localparam int ROWS = 16;
    localparam int WLB  = 64;
    localparam int IOB  = 16;
    localparam int NBLK = WLB / IOB;
    localparam int PW   = ROWS * NBLK;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic [3:0]     req_row = '0;
    logic [1:0]     req_blk = '0;
    logic [IOB-1:0] wdata = '0;
    logic           hold = 1'b0;
    logic           shutdown = 1'b0;
    logic [IOB-1:0] rdata;
    logic           rvalid;
    logic           rd_invalid;
    logic           pwr_err;
    logic [PW-1:0]  block_power;

    int checks = 0;
    int errors = 0;

    logic [IOB-1:0] m_mem [ROWS][NBLK];
    bit             m_vld [ROWS][NBLK];
    int             m_state = 0;

    always #2 clk = ~clk;

    cogated_sram #(.ROWS(ROWS), .WL_BITS(WLB), .IO_BITS(IOB)) i_cogated_sram (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_blk(req_blk), .wdata(wdata), .hold(hold),
        .shutdown(shutdown), .rdata(rdata), .rvalid(rvalid), .rd_invalid(rd_invalid),
        .pwr_err(pwr_err), .block_power(block_power)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int next_state(int s, bit ret, bit cut);
        if (cut) return 2;
        if (ret) return 1;
        if (s == 1 || s == 2) return 3;
        return 0;
    endfunction

    task automatic step(input string tag, input bit v, input bit w, input int row,
                        input int blk, input logic [IOB-1:0] d, input bit ret, input bit cut);
        bit ready, acc;
        logic [PW-1:0]  e_bp;
        bit             e_rv, e_inv, e_pe;
        logic [IOB-1:0] e_rd;
        req_valid = v; req_write = w; req_row = 4'(row); req_blk = 2'(blk);
        wdata = d; hold = ret; shutdown = cut;
        ready = (m_state == 0) && !ret && !cut;
        acc   = v && ready;
        e_bp  = acc ? (PW'(1) << (row*NBLK+blk)) : '0;
        e_rv  = acc && !w;
        e_inv = e_rv && !m_vld[row][blk];
        e_rd  = (e_rv && m_vld[row][blk]) ? m_mem[row][blk] : '0;
        e_pe  = v && !ready;
        if (acc && w) begin
            m_mem[row][blk] = d;
            m_vld[row][blk] = 1'b1;
        end
        if (cut) begin
            for (int r = 0; r < ROWS; r++)
                for (int b = 0; b < NBLK; b++) m_vld[r][b] = 1'b0;
        end
        m_state = next_state(m_state, ret, cut);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R1 block_power"}, 64'(block_power), 64'(e_bp));
        chk({tag, " R2 rvalid"}, 64'(rvalid), 64'(e_rv));
        chk({tag, " R2/R3 rdata"}, 64'(rdata), 64'(e_rd));
        chk({tag, " R4 rd_invalid"}, 64'(rd_invalid), 64'(e_inv));
        chk({tag, " R7 pwr_err"}, 64'(pwr_err), 64'(e_pe));
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, '0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int r = 0; r < ROWS; r++)
            for (int b = 0; b < NBLK; b++) begin
                m_mem[r][b] = '0;
                m_vld[r][b] = 1'b0;
            end
        repeat (3) @(negedge clk);
        chk("reset R1 block_power", 64'(block_power), 64'd0);
        chk("reset R2 rvalid", 64'(rvalid), 64'd0);
        chk("reset R7 pwr_err", 64'(pwr_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: unwritten word is invalid
        step("r4_unwritten", 1, 0, 3, 1, '0, 0, 0);
        // R2 R3: write then read back
        step("r3_wr", 1, 1, 3, 1, 16'hA5A5, 0, 0);
        step("r2_rd", 1, 0, 3, 1, '0, 0, 0);
        // R3: neighbouring slices of one row
        for (int b = 0; b < NBLK; b++) step("r3_row_wr", 1, 1, 5, b, 16'(16'h1100 + b), 0, 0);
        for (int b = 0; b < NBLK; b++) step("r3_row_rd", 1, 0, 5, b, '0, 0, 0);
        step("r3_other_row", 1, 0, 4, 2, '0, 0, 0);
        step("r3_last", 1, 1, ROWS-1, NBLK-1, 16'hFFFF, 0, 0);
        step("r3_last_rd", 1, 0, ROWS-1, NBLK-1, '0, 0, 0);
        idle("r1_idle");

        // R6 R7 R8: retention with rejected accesses and wake cycle
        step("r7_hold_wr", 1, 1, 5, 0, 16'hDEAD, 1, 0);
        step("r7_hold_rd", 1, 0, 5, 0, '0, 1, 0);
        step("r8_drop", 1, 0, 5, 0, '0, 0, 0);
        step("r8_wake", 1, 0, 5, 0, '0, 0, 0);
        step("r6_after", 1, 0, 5, 0, '0, 0, 0);
        step("r6_after2", 1, 0, 3, 1, '0, 0, 0);

        // R5 R9: both controls, shutdown wins
        step("r9_both", 1, 0, 3, 1, '0, 1, 1);
        step("r9_hold_only", 0, 0, 0, 0, '0, 1, 0);
        step("r8_drop2", 0, 0, 0, 0, '0, 0, 0);
        step("r8_wake2", 1, 1, 3, 1, 16'h0BAD, 0, 0);
        step("r5_lost", 1, 0, 3, 1, '0, 0, 0);
        step("r5_lost2", 1, 0, 5, 2, '0, 0, 0);
        step("r4_rewrite", 1, 1, 5, 2, 16'h7777, 0, 0);
        step("r4_valid", 1, 0, 5, 2, '0, 0, 0);

        // random traffic
        for (int i = 0; i < 1500; i++) begin
            int  sel;
            bit  ret, cut;
            sel = int'($urandom % 100);
            ret = (sel < 6);
            cut = (sel >= 6 && sel < 8) || (sel == 8);
            if (sel == 8) ret = 1'b1;
            step("rnd_R1_R3", ($urandom % 4) != 0, ($urandom % 2) == 1,
                 int'($urandom % ROWS), int'($urandom % NBLK),
                 16'($urandom), ret, cut);
        end
        idle("final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule